// File: doc/BRIEF.md
# Accuracy-Aware Memory Request Scheduler

This block chooses which pending memory request goes to the DRAM next. It looks at a small request buffer shared by several cores. Each occupied slot describes its request: whether it is a demand or a prefetch, which core issued it, and which bank and row it targets. The block also receives a measured prefetch accuracy for each core, given as a percentage, and the open row of every bank. It makes a fresh choice on every bus cycle and presents the winning slot index on registered outputs.

The block classifies each request in two ways. A request is critical when it is a demand, or when it is a prefetch from a core whose accuracy is at least the promotion threshold of 85 percent. A request is urgent when it is a demand from a core whose accuracy is below that threshold. As a result, prefetches from a core with poor accuracy wait behind demands, and demands from that core are not starved. Requests from a core with good accuracy compete on row locality alone, whether they are demands or prefetches.

The buffer storage itself is outside the block, but the block keeps an age counter for every slot. A slot's allocate pulse clears its counter.

Top module: `acc_mem_sched`

## Requirements
- R1: `gnt_valid_o` is 0 while reset is held and in the cycle after any cycle in which no slot is valid. It is 1 in the cycle after any cycle in which at least one slot is valid.
- R2: A request is critical if `ent_pref_i` is 0 (demand), or if `ent_pref_i` is 1 and the accuracy of its core is at least 85.
- R3: A request is urgent only if it is a demand and the accuracy of its core is below 85. Accuracy 84 is urgent and accuracy 85 is not.
- R4: Priority is decided in this order, strongest first: critical, then row hit, then urgent, then greater age. A higher rank always beats any combination of the lower ranks.
- R5: A request is a row hit only when the `bank_open_i` bit of its bank is 1 and the entry's row equals that bank's row in `bank_row_i`. A matching row in a closed bank is not a hit.
- R6: A slot's age becomes 0 on the edge where its allocate bit is 1. On each later edge while the slot is valid, the age rises by 1 until it saturates at 2^AGE_W-1. When all other fields tie and the ages are equal, including when both ages have saturated, the lowest index wins.
- R7: The grant outputs are registered. They reflect the inputs and ages seen at the previous rising edge, and they are recomputed on every edge, so a change in accuracy takes effect in the next cycle.
- R8: `gnt_crit_o`, `gnt_hit_o` and `gnt_urg_o` give the winner's classification. An urgent winner is always also critical. When any valid demand was present, the winner is critical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ent_valid_i | input | NUM_ENTRIES | Slot occupied |
| ent_alloc_i | input | NUM_ENTRIES | Slot newly filled this cycle; clears its age |
| ent_pref_i | input | NUM_ENTRIES | 1 = prefetch, 0 = demand |
| ent_core_i | input | NUM_ENTRIES*CORE_W | Issuing core per slot, slot 0 in the low bits |
| ent_bank_i | input | NUM_ENTRIES*BANK_W | Target bank per slot |
| ent_row_i | input | NUM_ENTRIES*ROW_W | Target row per slot |
| core_acc_i | input | NUM_CORES*ACC_W | Prefetch accuracy per core, 0 to 100 percent |
| bank_open_i | input | NUM_BANKS | Bank has a row open |
| bank_row_i | input | NUM_BANKS*ROW_W | Open row per bank |
| gnt_valid_o | output | 1 | A winner is presented |
| gnt_idx_o | output | IDX_W | Winning slot index |
| gnt_crit_o | output | 1 | Winner is critical |
| gnt_hit_o | output | 1 | Winner is a row hit |
| gnt_urg_o | output | 1 | Winner is urgent |

## Verification
A wrong age counter or a stuck classification bit in one slot would not appear until that slot competed with a rival that differs from it in exactly one field. The bench therefore builds two-slot contests that isolate one rank at a time, and it samples each result one cycle after the deciding input. A saturation fault would go unseen for more than 2^AGE_W cycles, so one contest runs long enough for both ages to saturate and then expects the tie to go to the lower index. A mistaken comparison at the threshold would show as a wrong winner in the very next cycle after an accuracy moves from 85 to 84.

// File: rtl/acc_sched_pkg.sv
package acc_sched_pkg;
  typedef struct packed {
    logic crit;
    logic hit;
    logic urg;
  } prio_flags_t;
endpackage

// File: rtl/acc_promote.sv
module acc_promote #(
  parameter int NUM_CORES = 4,
  parameter int ACC_W     = 7,
  parameter int PROMO_PCT = 85
) (
  input  logic [NUM_CORES*ACC_W-1:0] core_acc_i,
  output logic [NUM_CORES-1:0]       promoted_o
);
  localparam logic [ACC_W-1:0] THRESH = ACC_W'(PROMO_PCT);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign promoted_o[c] = core_acc_i[c*ACC_W +: ACC_W] >= THRESH;
  end
endmodule

// File: rtl/age_track.sv
module age_track #(
  parameter int NUM_ENTRIES = 8,
  parameter int AGE_W       = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_ENTRIES-1:0]       valid_i,
  input  logic [NUM_ENTRIES-1:0]       alloc_i,
  output logic [NUM_ENTRIES*AGE_W-1:0] age_o
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_age
    logic [AGE_W-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst || alloc_i[e] || !valid_i[e]) cnt_q <= '0;
      else if (cnt_q != AGE_MAX)            cnt_q <= cnt_q + 1'b1;
    end
    assign age_o[e*AGE_W +: AGE_W] = cnt_q;
  end
endmodule

// File: rtl/entry_prio.sv
module entry_prio
  import acc_sched_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       pref_i,
  input  logic [CORE_W-1:0]          core_i,
  input  logic [BANK_W-1:0]          bank_i,
  input  logic [ROW_W-1:0]           row_i,
  input  logic [NUM_CORES-1:0]       promoted_i,
  input  logic [NUM_BANKS-1:0]       bank_open_i,
  input  logic [NUM_BANKS*ROW_W-1:0] bank_row_i,
  output prio_flags_t                flags_o
);
  logic good_core;
  logic [ROW_W-1:0] open_row;

  always_comb begin
    good_core     = promoted_i[core_i];
    open_row      = bank_row_i[bank_i*ROW_W +: ROW_W];
    flags_o.crit  = !pref_i || good_core;
    flags_o.urg   = !pref_i && !good_core;
    flags_o.hit   = bank_open_i[bank_i] && (open_row == row_i);
  end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int NUM_ENTRIES = 8,
  parameter int KEY_W       = 9,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [NUM_ENTRIES-1:0]       valid_i,
  input  logic [NUM_ENTRIES*KEY_W-1:0] key_i,
  output logic                         any_o,
  output logic [IDX_W-1:0]             idx_o,
  output logic [KEY_W-1:0]             key_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    key_o = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (valid_i[i] && (!any_o || key_i[i*KEY_W +: KEY_W] > key_o)) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
        key_o = key_i[i*KEY_W +: KEY_W];
      end
    end
  end
endmodule

// File: rtl/acc_mem_sched.sv
module acc_mem_sched
  import acc_sched_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_CORES   = 4,
  parameter int NUM_BANKS   = 4,
  parameter int ROW_W       = 8,
  parameter int AGE_W       = 6,
  parameter int ACC_W       = 7,
  parameter int PROMO_PCT   = 85,
  localparam int CORE_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_ENTRIES-1:0]        ent_valid_i,
  input  logic [NUM_ENTRIES-1:0]        ent_alloc_i,
  input  logic [NUM_ENTRIES-1:0]        ent_pref_i,
  input  logic [NUM_ENTRIES*CORE_W-1:0] ent_core_i,
  input  logic [NUM_ENTRIES*BANK_W-1:0] ent_bank_i,
  input  logic [NUM_ENTRIES*ROW_W-1:0]  ent_row_i,
  input  logic [NUM_CORES*ACC_W-1:0]    core_acc_i,
  input  logic [NUM_BANKS-1:0]          bank_open_i,
  input  logic [NUM_BANKS*ROW_W-1:0]    bank_row_i,
  output logic                          gnt_valid_o,
  output logic [IDX_W-1:0]              gnt_idx_o,
  output logic                          gnt_crit_o,
  output logic                          gnt_hit_o,
  output logic                          gnt_urg_o
);
  localparam int KEY_W = 3 + AGE_W;

  logic [NUM_CORES-1:0]         promoted;
  logic [NUM_ENTRIES*AGE_W-1:0] ages;
  logic [NUM_ENTRIES*KEY_W-1:0] keys;
  logic                         win_any;
  logic [IDX_W-1:0]             win_idx;
  logic [KEY_W-1:0]             win_key;

  acc_promote #(.NUM_CORES(NUM_CORES), .ACC_W(ACC_W), .PROMO_PCT(PROMO_PCT)) u_promote (
    .core_acc_i (core_acc_i),
    .promoted_o (promoted)
  );

  age_track #(.NUM_ENTRIES(NUM_ENTRIES), .AGE_W(AGE_W)) u_age (
    .clk     (clk),
    .rst     (rst),
    .valid_i (ent_valid_i),
    .alloc_i (ent_alloc_i),
    .age_o   (ages)
  );

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    prio_flags_t fl;
    entry_prio #(.NUM_CORES(NUM_CORES), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_prio (
      .pref_i      (ent_pref_i[e]),
      .core_i      (ent_core_i[e*CORE_W +: CORE_W]),
      .bank_i      (ent_bank_i[e*BANK_W +: BANK_W]),
      .row_i       (ent_row_i[e*ROW_W +: ROW_W]),
      .promoted_i  (promoted),
      .bank_open_i (bank_open_i),
      .bank_row_i  (bank_row_i),
      .flags_o     (fl)
    );
    assign keys[e*KEY_W +: KEY_W] = {fl.crit, fl.hit, fl.urg, ages[e*AGE_W +: AGE_W]};
  end

  prio_pick #(.NUM_ENTRIES(NUM_ENTRIES), .KEY_W(KEY_W)) u_pick (
    .valid_i (ent_valid_i),
    .key_i   (keys),
    .any_o   (win_any),
    .idx_o   (win_idx),
    .key_o   (win_key)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_valid_o <= 1'b0;
      gnt_idx_o   <= '0;
      gnt_crit_o  <= 1'b0;
      gnt_hit_o   <= 1'b0;
      gnt_urg_o   <= 1'b0;
    end else begin
      gnt_valid_o <= win_any;
      gnt_idx_o   <= win_idx;
      gnt_crit_o  <= win_any && win_key[KEY_W-1];
      gnt_hit_o   <= win_any && win_key[KEY_W-2];
      gnt_urg_o   <= win_any && win_key[KEY_W-3];
    end
  end
endmodule

// File: rtl/acc_mem_sched_chk.sv
module acc_mem_sched_chk #(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_ENTRIES-1:0] ent_valid_i,
  input logic [NUM_ENTRIES-1:0] ent_pref_i,
  input logic                   gnt_valid_o,
  input logic [IDX_W-1:0]       gnt_idx_o,
  input logic                   gnt_crit_o,
  input logic                   gnt_urg_o
);
  logic [NUM_ENTRIES-1:0] vld_q;
  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= ent_valid_i;
  end

  a_r1_idle_low: assert property (@(posedge clk) disable iff (rst)
    !(|ent_valid_i) |=> !gnt_valid_o);
  a_r1_busy_high: assert property (@(posedge clk) disable iff (rst)
    (|ent_valid_i) |=> gnt_valid_o);
  a_r7_winner_was_valid: assert property (@(posedge clk) disable iff (rst)
    gnt_valid_o |-> vld_q[gnt_idx_o]);
  a_r8_urgent_is_critical: assert property (@(posedge clk) disable iff (rst)
    gnt_urg_o |-> gnt_crit_o);
  a_r4_demand_present_crit: assert property (@(posedge clk) disable iff (rst)
    (|(ent_valid_i & ~ent_pref_i)) |=> gnt_crit_o);
endmodule

bind acc_mem_sched acc_mem_sched_chk #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ent_valid_i (ent_valid_i),
  .ent_pref_i  (ent_pref_i),
  .gnt_valid_o (gnt_valid_o),
  .gnt_idx_o   (gnt_idx_o),
  .gnt_crit_o  (gnt_crit_o),
  .gnt_urg_o   (gnt_urg_o)
);

// File: tb/sim_acc_mem_sched.sv
module sim_acc_mem_sched;
  localparam int N = 8, C = 4, B = 4, RW = 8, AW = 6, ACCW = 7;
  localparam int CW = 2, BW = 2, IW = 3;

  logic clk = 0, rst = 1;
  logic [N-1:0] valid = '0, alloc = '0, pref = '0;
  logic [N*CW-1:0] core = '0;
  logic [N*BW-1:0] bank = '0;
  logic [N*RW-1:0] row = '0;
  logic [C*ACCW-1:0] acc;
  logic [B-1:0] bopen;
  logic [B*RW-1:0] brow;
  logic g_v, g_c, g_h, g_u;
  logic [IW-1:0] g_i;
  int nchk = 0, nfail = 0, cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  acc_mem_sched u0 (
    .clk(clk), .rst(rst), .ent_valid_i(valid), .ent_alloc_i(alloc), .ent_pref_i(pref),
    .ent_core_i(core), .ent_bank_i(bank), .ent_row_i(row), .core_acc_i(acc),
    .bank_open_i(bopen), .bank_row_i(brow), .gnt_valid_o(g_v), .gnt_idx_o(g_i),
    .gnt_crit_o(g_c), .gnt_hit_o(g_h), .gnt_urg_o(g_u)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic ev, input int ei,
                     input logic ec, input logic eh, input logic eu);
    logic [6:0] act, exp;
    act = {g_v, g_i, g_c, g_h, g_u};
    exp = {ev, IW'(ei), ec, eh, eu};
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got v=%b idx=%0d c=%b h=%b u=%b, expected v=%b idx=%0d c=%b h=%b u=%b",
               req, g_v, g_i, g_c, g_h, g_u, ev, ei, ec, eh, eu);
    end
  endtask

  task automatic put(input int e, input logic p, input int c, input int b, input int r);
    pref[e] = p;
    core[e*CW +: CW] = CW'(c);
    bank[e*BW +: BW] = BW'(b);
    row[e*RW +: RW] = RW'(r);
  endtask

  task automatic add(input int e);
    alloc[e] = 1'b1;
    valid[e] = 1'b1;
    step(1);
    alloc = '0;
  endtask

  task automatic clear();
    valid = '0;
    step(2);
  endtask

  // core0=100, core1=10, core2=85, core3=84
  task automatic set_acc(input int a0, input int a1, input int a2, input int a3);
    acc = {ACCW'(a3), ACCW'(a2), ACCW'(a1), ACCW'(a0)};
  endtask

  task automatic t_reset();
    chk("R1 reset", 0, 0, 0, 0, 0);
    rst = 0;
    step(2);
    chk("R1 idle", 0, 0, 0, 0, 0);
  endtask

  task automatic t_crit_over_hit();
    clear();
    put(1, 1, 1, 1, 7);   // prefetch, bad core, row hit, older
    put(0, 0, 3, 0, 5);   // demand, core at 84, miss
    add(1); step(2); add(0); step(1);
    chk("R4 R2 critical beats row hit", 1, 0, 1, 0, 1);
  endtask

  task automatic t_hit_over_urg();
    clear();
    put(0, 0, 1, 0, 5);   // urgent demand, miss, older
    put(1, 0, 0, 1, 7);   // good-core demand, hit
    add(0); step(2); add(1); step(1);
    chk("R4 R5 row hit beats urgent", 1, 1, 1, 1, 0);
  endtask

  task automatic t_urg_over_age();
    clear();
    put(0, 0, 0, 0, 5);
    put(1, 0, 1, 2, 3);   // bank2 holds row 4: miss
    add(0); step(3); add(1); step(1);
    chk("R4 R3 urgent beats age", 1, 1, 1, 0, 1);
  endtask

  task automatic t_oldest();
    clear();
    put(3, 0, 0, 0, 1);
    put(6, 0, 0, 0, 2);
    add(6); step(2); add(3); step(1);
    chk("R6 oldest wins", 1, 6, 1, 0, 0);
  endtask

  task automatic t_threshold();
    clear();
    put(0, 1, 2, 0, 1);   // prefetch, core at 85, miss
    put(1, 1, 3, 1, 7);   // prefetch, core at 84, hit, older
    add(1); step(1); add(0); step(1);
    chk("R2 prefetch at 85 is critical", 1, 0, 1, 0, 0);
    set_acc(100, 10, 84, 84);
    step(1);
    chk("R7 R2 accuracy drop applies next cycle", 1, 1, 0, 1, 0);
    set_acc(100, 10, 85, 84);
    step(1);
  endtask

  task automatic t_closed_bank();
    clear();
    put(0, 1, 0, 3, 2);   // row matches bank3 register, bank3 closed, older
    put(1, 1, 0, 1, 7);   // hit in bank1
    add(0); step(2); add(1); step(1);
    chk("R5 closed bank no hit", 1, 1, 1, 1, 0);
    bopen[3] = 1'b1;
    step(1);
    chk("R5 opened bank hits", 1, 0, 1, 1, 0);
    bopen[3] = 1'b0;
  endtask

  task automatic t_saturate();
    clear();
    put(5, 0, 0, 0, 1);
    put(2, 0, 0, 0, 1);
    add(5); step(9); add(2); step(4);
    chk("R6 older wins before saturation", 1, 5, 1, 0, 0);
    step(80);
    chk("R6 saturated tie lowest index", 1, 2, 1, 0, 0);
  endtask

  task automatic t_idle_after();
    valid = '0;
    step(1);
    chk("R1 no valid entry", 0, 0, 0, 0, 0);
  endtask

  initial begin
    set_acc(100, 10, 85, 84);
    bopen = 4'b0111;
    brow = {RW'(2), RW'(4), RW'(7), RW'(9)};
    step(3);
    t_reset();
    t_crit_over_hit();
    t_hit_over_urg();
    t_urg_over_age();
    t_oldest();
    t_threshold();
    t_closed_bank();
    t_saturate();
    t_idle_after();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    nchk++;
    nfail++;
    $display("FAIL watchdog: got cycle %0d, expected completion", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule